// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Access Statistics

This block sits between a processor core and a 64 KB byte-addressable memory. It holds eight lines of two bytes each, selected directly by the address, and answers 16-bit little-endian word reads and writes from the core. A request that finds its line absent first pulls the whole line from memory. Every write also goes straight through to memory, and the written line stays in the cache.

A word at an odd address straddles two lines. The block handles it as two single-byte accesses, one after the other. Each half is looked up, and counted, on its own.

Two saturating counters, one for hits and one for misses, let the surrounding system work out a hit ratio. A clear input zeroes both counters.

Top module: `word_cache`

## Requirements
- R1: After reset `core_ready` is low, both counters read zero and every line is invalid, so the first access to any address is a miss.
- R2: Address bit 0 picks the byte inside a line, bits 3:1 pick one of the eight lines and bits 15:4 are the tag. Two addresses that share bits 3:1 but differ in the tag evict each other.
- R3: A read miss issues exactly one memory read, and its `mem_addr` has bit 0 clear and `mem_be` = 2'b11. The returned word then comes from the filled line. A later read of the same line hits and issues no memory request.
- R4: Byte order is little-endian. The byte at address A sits in bits 7:0 of `core_rdata` and `core_wdata`, and the byte at A+1 sits in bits 15:8. On the memory side, `mem_be[0]` and data bits 7:0 belong to the even byte of a line.
- R5: Every write sends its bytes to memory in one memory write per line touched. An even-address write uses `mem_be` = 2'b11. A following read of the same word hits and returns the written data.
- R6: A write that misses fills the line from memory before it merges the new bytes. The untouched byte of that line therefore keeps the memory's value.
- R7: A word access at an odd address A is split into two byte accesses, on the line of A and on the line of A+1. The second half may land on line 0 with the next tag. A split write sends `mem_be` = 2'b10 for the first half and 2'b01 for the second.
- R8: Each lookup adds exactly one to either the hit count or the miss count. An aligned access makes one lookup and a split access makes two.
- R9: A counter that holds its maximum value stays there.
- R10: While `stat_clear` is high, both counters read zero on the next cycle, even if a lookup happens in that cycle.
- R11: Each accepted request gets exactly one single-cycle `core_ready` pulse, with `core_rdata` valid in that cycle. A `core_req` raised while a request is in progress is ignored.
- R12: Once `mem_req` is raised, it stays high with the same address, direction and byte enables until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Request strobe, sampled only while idle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Byte address of the word |
| core_wdata | input | 16 | Write word, low byte at the address |
| core_rdata | output | 16 | Read word, valid with core_ready |
| core_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Line-aligned memory byte address |
| mem_be | output | 2 | Byte enables, bit 0 = even byte |
| mem_wdata | output | 16 | Line write data |
| mem_rdata | input | 16 | Line read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion |
| stat_clear | input | 1 | Zero both counters |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
The bench keeps the address width at 16 and the eight-line geometry. Those fixed sizes make eviction, the wrap of a split access from line 7 into line 0, and the exact tag and index values in each test hold as written. It narrows the counters to 4 bits, so a count of 15 is reached after a short run of hits, and the bench can show the counter holding there.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_FILL,
        ST_APPLY,
        ST_WRITE,
        ST_DONE
    } wc_state_e;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned LINE_BYTES = 2;

endpackage

// File: rtl/wc_tag_store.sv
module wc_tag_store #(
    parameter int unsigned LINES = 8,
    parameter int unsigned TAG_W = 12,
    parameter int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < LINES; i++) begin
            tag_d[i] = tag_q[i];
        end
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= tag_d[i];
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/wc_line_store.sv
module wc_line_store #(
    parameter int unsigned LINES = 8,
    parameter int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_be,
    input  logic [15:0]      wr_line
);

    logic [15:0] line_d [LINES];
    logic [15:0] line_q [LINES];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_d[i] = line_q[i];
        end
        if (wr_en) begin
            for (int b = 0; b < 2; b++) begin
                if (wr_be[b]) begin
                    line_d[wr_idx][8*b +: 8] = wr_line[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                line_q[i] <= line_d[i];
            end
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/wc_sat_counter.sv
module wc_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != {W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/word_cache.sv
module word_cache
    import wcache_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LINES  = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [15:0]       core_wdata,
    output logic [15:0]       core_rdata,
    output logic              core_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              stat_clear,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - 1;

    typedef struct packed {
        wc_state_e         st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
        logic              split;
        logic              part;
        logic [15:0]       rdata;
    } wc_regs_t;

    wc_regs_t r_d, r_q;

    logic [ADDR_W-1:0] part_addr;
    logic [IDX_W-1:0]  part_idx;
    logic [TAG_W-1:0]  part_tag;
    logic [1:0]        part_be;
    logic [15:0]       part_wline;

    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic              look_hit;
    logic [15:0]       cur_line;

    logic              tag_we;
    logic              line_we;
    logic [1:0]        line_be;
    logic [15:0]       line_wdata;
    logic              hit_inc;
    logic              miss_inc;
    logic              advance;

    // Address of the half being served and its line fields
    assign part_addr = r_q.part ? (r_q.addr + ADDR_W'(1)) : r_q.addr;
    assign part_idx  = part_addr[IDX_W:1];
    assign part_tag  = part_addr[ADDR_W-1:IDX_W+1];
    assign look_hit  = look_valid && (look_tag == part_tag);

    always_comb begin
        if (!r_q.split) begin
            part_be    = 2'b11;
            part_wline = r_q.wdata;
        end else if (!r_q.part) begin
            part_be    = 2'b10;
            part_wline = {r_q.wdata[7:0], 8'h00};
        end else begin
            part_be    = 2'b01;
            part_wline = {8'h00, r_q.wdata[15:8]};
        end
    end

    wc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (part_idx),
        .rd_valid (look_valid),
        .rd_tag   (look_tag),
        .wr_en    (tag_we),
        .wr_idx   (part_idx),
        .wr_tag   (part_tag)
    );

    wc_line_store #(
        .LINES (LINES),
        .IDX_W (IDX_W)
    ) i_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (part_idx),
        .rd_line (cur_line),
        .wr_en   (line_we),
        .wr_idx  (part_idx),
        .wr_be   (line_be),
        .wr_line (line_wdata)
    );

    wc_sat_counter #(.W(CNT_W)) i_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_clear),
        .inc   (hit_inc),
        .cnt   (hit_count)
    );

    wc_sat_counter #(.W(CNT_W)) i_misses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (stat_clear),
        .inc   (miss_inc),
        .cnt   (miss_count)
    );

    always_comb begin
        r_d        = r_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {part_addr[ADDR_W-1:1], 1'b0};
        mem_be     = part_be;
        mem_wdata  = part_wline;
        core_ready = 1'b0;
        core_rdata = r_q.rdata;
        tag_we     = 1'b0;
        line_we    = 1'b0;
        line_be    = part_be;
        line_wdata = part_wline;
        hit_inc    = 1'b0;
        miss_inc   = 1'b0;
        advance    = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (core_req) begin
                    r_d.we    = core_we;
                    r_d.addr  = core_addr;
                    r_d.wdata = core_wdata;
                    r_d.split = core_addr[0];
                    r_d.part  = 1'b0;
                    r_d.rdata = '0;
                    r_d.st    = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (look_hit) begin
                    hit_inc = 1'b1;
                    r_d.st  = ST_APPLY;
                end else begin
                    miss_inc = 1'b1;
                    r_d.st   = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                mem_be  = 2'b11;
                if (mem_ack) begin
                    tag_we     = 1'b1;
                    line_we    = 1'b1;
                    line_be    = 2'b11;
                    line_wdata = mem_rdata;
                    r_d.st     = ST_APPLY;
                end
            end
            ST_APPLY: begin
                if (r_q.we) begin
                    line_we = 1'b1;
                    r_d.st  = ST_WRITE;
                end else begin
                    if (!r_q.split) begin
                        r_d.rdata = cur_line;
                    end else if (!r_q.part) begin
                        r_d.rdata[7:0] = cur_line[15:8];
                    end else begin
                        r_d.rdata[15:8] = cur_line[7:0];
                    end
                    advance = 1'b1;
                end
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    advance = 1'b1;
                end
            end
            ST_DONE: begin
                core_ready = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (advance) begin
            if (r_q.split && !r_q.part) begin
                r_d.part = 1'b1;
                r_d.st   = ST_LOOK;
            end else begin
                r_d.st = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, we: 1'b0, addr: '0, wdata: '0,
                     split: 1'b0, part: 1'b0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic              mem_ack,
    input logic              stat_clear,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);

    // R11: completion lasts one cycle
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);

    // R12: pending memory request holds steady
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_be)));

    // R3: memory traffic is line aligned with some byte enabled
    a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!mem_addr[0] && (mem_be != 2'b00)));

    // R10: clear empties both counters
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clear |=> ((hit_count == '0) && (miss_count == '0)));

    // R8: at most one counter moves, by one
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

    a_r8_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clear |=> ((hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + 1'b1)));

    // R9: saturated counters stay put
    a_r9_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_count == {CNT_W{1'b1}}) && !stat_clear) |=> (hit_count == {CNT_W{1'b1}}));

    a_r9_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_count == {CNT_W{1'b1}}) && !stat_clear) |=> (miss_count == {CNT_W{1'b1}}));

endmodule

bind word_cache wc_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) i_wc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ready (core_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_ack    (mem_ack),
    .stat_clear (stat_clear),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/test_word_cache.sv
module test_word_cache;

    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic [15:0] core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        core_ready;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        stat_clear = 1'b0;
    logic [CNT_W-1:0] hit_count;
    logic [CNT_W-1:0] miss_count;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    word_cache #(.ADDR_W(16), .LINES(8), .CNT_W(CNT_W)) i_word_cache (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .stat_clear(stat_clear), .hit_count(hit_count), .miss_count(miss_count)
    );

    // ---------------- memory model ----------------
    logic [7:0] wr_mem [int];
    int rd_ops = 0;
    int wr_ops = 0;
    logic [1:0] last_be = '0;
    int hold_err = 0;
    int lat = 0;
    logic pend = 1'b0;
    logic [15:0] pend_addr = '0;

    function automatic logic [7:0] init_byte(int a);
        logic [15:0] x;
        x = 16'(a);
        return x[7:0] ^ x[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rd_byte(int a);
        if (wr_mem.exists(a)) return wr_mem[a];
        return init_byte(a);
    endfunction

    always @(posedge clk) begin
        if (pend && (!mem_req || mem_addr != pend_addr)) hold_err++;
        pend      <= mem_req && !mem_ack;
        pend_addr <= mem_addr;
        if (mem_req && !mem_ack) begin
            if (lat == 2) begin
                lat     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    wr_ops++;
                    last_be = mem_be;
                    if (mem_be[0]) wr_mem[int'(mem_addr)]     = mem_wdata[7:0];
                    if (mem_be[1]) wr_mem[int'(mem_addr) + 1] = mem_wdata[15:8];
                end else begin
                    rd_ops++;
                    mem_rdata <= {rd_byte(int'(mem_addr) + 1), rd_byte(int'(mem_addr))};
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd);
        int n;
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
        @(negedge clk);
        core_req = 1'b0;
        n = 0;
        while (!core_ready && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R11", "ready seen", int'(core_ready), 1);
        rd = core_rdata;
    endtask

    task automatic clear_stats();
        @(negedge clk); stat_clear = 1'b1;
        @(negedge clk); stat_clear = 1'b0;
    endtask

    function automatic logic [15:0] mword(int a);
        return {rd_byte(a + 1), rd_byte(a)};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] d;
        int r0;
        chk("R1", "ready after reset", int'(core_ready), 0);
        chk("R1", "hits after reset", int'(hit_count), 0);
        chk("R1", "misses after reset", int'(miss_count), 0);
        r0 = rd_ops;
        access(1'b0, 16'h0100, 16'h0, d);
        chk("R1", "first access misses", int'(miss_count), 1);
        chk("R3", "one fill on miss", rd_ops - r0, 1);
        chk("R4", "read miss data", int'(d), int'(mword(16'h0100)));
    endtask

    task automatic t_read_hit();
        logic [15:0] d;
        int r0;
        r0 = rd_ops;
        access(1'b0, 16'h0100, 16'h0, d);
        chk("R3", "repeat read hits", int'(hit_count), 1);
        chk("R3", "no memory on hit", rd_ops - r0, 0);
        chk("R4", "hit data little-endian", int'(d), int'(mword(16'h0100)));
    endtask

    task automatic t_conflict();
        logic [15:0] d;
        clear_stats();
        access(1'b0, 16'h0110, 16'h0, d);   // same line 0, new tag
        access(1'b0, 16'h0100, 16'h0, d);   // evicted, misses again
        access(1'b0, 16'h0102, 16'h0, d);   // line 1
        access(1'b0, 16'h0100, 16'h0, d);   // still on line 0
        chk("R2", "conflict misses", int'(miss_count), 3);
        chk("R2", "other line keeps hit", int'(hit_count), 1);
        chk("R2", "data after refill", int'(d), int'(mword(16'h0100)));
    endtask

    task automatic t_write();
        logic [15:0] d;
        int r0, w0;
        clear_stats();
        r0 = rd_ops; w0 = wr_ops;
        access(1'b1, 16'h0200, 16'hBEEF, d);
        chk("R5", "write miss counted", int'(miss_count), 1);
        chk("R5", "one memory write", wr_ops - w0, 1);
        chk("R5", "full enables", int'(last_be), 3);
        chk("R4", "low byte in memory", int'(rd_byte(16'h0200)), 16'hEF);
        chk("R4", "high byte in memory", int'(rd_byte(16'h0201)), 16'hBE);
        r0 = rd_ops;
        access(1'b0, 16'h0200, 16'h0, d);
        chk("R5", "read after write hits", int'(hit_count), 1);
        chk("R5", "allocated data", int'(d), 16'hBEEF);
        chk("R5", "no fill after allocate", rd_ops - r0, 0);
    endtask

    task automatic t_odd_read();
        logic [15:0] d;
        logic [15:0] e;
        int r0;
        clear_stats();
        r0 = rd_ops;
        e = {rd_byte(16'h0306), rd_byte(16'h0305)};
        access(1'b0, 16'h0305, 16'h0, d);
        chk("R7", "split read data", int'(d), int'(e));
        chk("R8", "two misses for split", int'(miss_count), 2);
        chk("R7", "two fills", rd_ops - r0, 2);
        access(1'b0, 16'h0306, 16'h0, d);
        chk("R8", "second line now hits", int'(hit_count), 1);
        clear_stats();
        e = {rd_byte(16'h0410), rd_byte(16'h040F)};
        access(1'b0, 16'h040F, 16'h0, d);
        chk("R7", "wrap split data", int'(d), int'(e));
        chk("R8", "wrap split misses", int'(miss_count), 2);
    endtask

    task automatic t_odd_write();
        logic [15:0] d;
        int w0;
        logic [7:0] other;
        clear_stats();
        other = rd_byte(16'h0502);
        w0 = wr_ops;
        access(1'b1, 16'h0503, 16'h1234, d);
        chk("R7", "two writes for split", wr_ops - w0, 2);
        chk("R7", "second half enable", int'(last_be), 1);
        chk("R4", "odd byte stored", int'(rd_byte(16'h0503)), 16'h34);
        chk("R4", "next byte stored", int'(rd_byte(16'h0504)), 16'h12);
        chk("R8", "split write misses", int'(miss_count), 2);
        access(1'b0, 16'h0502, 16'h0, d);
        chk("R6", "merged line", int'(d), int'({8'h34, other}));
        chk("R6", "merged line hit", int'(hit_count), 1);
    endtask

    task automatic t_busy();
        int pulses, w0, r0;
        w0 = wr_ops; r0 = rd_ops;
        @(negedge clk);
        core_req = 1'b1; core_we = 1'b0; core_addr = 16'h0700;
        @(negedge clk);
        core_we = 1'b1; core_addr = 16'h0800; core_wdata = 16'hAAAA;
        @(negedge clk);
        @(negedge clk);
        core_req = 1'b0; core_we = 1'b0;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            if (core_ready) pulses++;
            @(negedge clk);
        end
        chk("R11", "one completion", pulses, 1);
        chk("R11", "busy write ignored", wr_ops - w0, 0);
        chk("R11", "single fill", rd_ops - r0, 1);
    endtask

    task automatic t_clear_priority();
        logic [15:0] d;
        access(1'b0, 16'h0100, 16'h0, d);
        @(negedge clk); stat_clear = 1'b1;
        access(1'b0, 16'h0100, 16'h0, d);
        @(negedge clk); stat_clear = 1'b0;
        @(negedge clk);
        chk("R10", "hits held at zero", int'(hit_count), 0);
        chk("R10", "misses held at zero", int'(miss_count), 0);
    endtask

    task automatic t_saturate();
        logic [15:0] d;
        access(1'b0, 16'h0100, 16'h0, d);
        clear_stats();
        for (int i = 0; i < 20; i++) begin
            access(1'b0, 16'h0100, 16'h0, d);
        end
        chk("R9", "hits saturate", int'(hit_count), 15);
        chk("R9", "misses untouched", int'(miss_count), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_hit();
        t_conflict();
        t_write();
        t_odd_read();
        t_odd_write();
        t_busy();
        t_clear_priority();
        t_saturate();
        chk("R12", "request dropped early", hold_err, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule